// File: doc/BRIEF.md
# Pipelined Cascadable Multiplier-Summer

This block is a registered multiply-add datapath that forms (A×B)+C on two's complement numbers. It is meant as one tap of a cascaded FIR filter, or as one step of a polynomial evaluator in Horner form. Two 12-bit operands go through their own load-enabled registers into a signed multiplier. The 24-bit product is registered, sign-extended to 26 bits and added to a 26-bit addend. The addend comes from its own load-enabled register, which is fed from outside the block, so an upstream tap's sum can be chained into it. Any carry out of the 26-bit sum is dropped, so the sum wraps modulo 2^26.

The sum always goes into an output register on each clock. A feedthrough select chooses what the output port shows: the live adder result, or the registered copy one cycle later. The registered path lets a cascade insert a zero-coefficient delay tap, or run two interleaved sample streams on alternate cycles. An output-disable control forces the port to zero and drops `out_valid`, and takes the place of a high-impedance output. The data pins carry no valid/ready handshake and apply no back-pressure. The block takes new operands on every clock whose load enable is high. The output must be consumed in the cycle it is shown, because nothing stalls the pipeline.

Top module: `msum_top`

## Requirements
- R1: Each 12-bit operand register (A, B) takes its input at a rising edge when its own load enable is 1 and otherwise keeps its value.
- R2: The operands are two's complement, and their 24-bit signed product is registered at the edge after the operands were registered (-2048×-2048 gives +4194304).
- R3: The 26-bit addend register takes `c_in` at a rising edge when `c_load` is 1 and otherwise keeps its value.
- R4: The live sum is the addend register plus the product register sign-extended to 26 bits, modulo 2^26, with no carry or overflow output.
- R5: The output register captures the live sum at every rising edge that is not in reset.
- R6: With `pass_thru`=1 and `out_dis`=0, `sum_out` shows the live sum in the same cycle. A product of operands loaded at edge k therefore appears after edge k+1, added to the addend held after edge k+1.
- R7: With `pass_thru`=0 and `out_dis`=0, `sum_out` shows the output register, which is the live sum one cycle late.
- R8: `out_dis`=1 forces `sum_out` to 0 and `out_valid` to 0. With `out_dis`=0, `out_valid` is 1.
- R9: A synchronous active-high `rst` clears the operand, addend, product and output registers to 0. The load enables have no effect while `rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 12 | Operand A, two's complement |
| a_load | input | 1 | Load enable for operand A register |
| b_in | input | 12 | Operand B, two's complement |
| b_load | input | 1 | Load enable for operand B register |
| c_in | input | 26 | Addend, two's complement |
| c_load | input | 1 | Load enable for addend register |
| pass_thru | input | 1 | 1: show live sum; 0: show registered sum |
| out_dis | input | 1 | 1: output disabled (zero, not valid) |
| sum_out | output | 26 | Sum output |
| out_valid | output | 1 | 1 when the output is enabled |

## Verification
The bench builds the block with its default widths: 12-bit operands and a 26-bit addend and sum. At these widths the full-scale corner products can be reached directly, and so can the case where a maximum product plus a large addend wraps past 2^25. A cycle-accurate reference model follows the pipeline one edge at a time. Under random load enables and output controls, it checks the alignment between operand loads at edge k and the addend held at edge k+1 on the feedthrough path, and the one-cycle lag on the registered path.

// File: rtl/msum_pkg.sv
package msum_pkg;
  // Output port source selection
  typedef enum logic [1:0] {
    OSEL_OFF  = 2'd0,
    OSEL_LIVE = 2'd1,
    OSEL_HELD = 2'd2
  } osel_e;
endpackage

// File: rtl/msum_ld_reg.sv
module msum_ld_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

  // R1 R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> (q == $past(q)));

  // R1 R3
  load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> (q == $past(d)));

  // R9
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (q == '0));
endmodule

// File: rtl/msum_mult.sv
module msum_mult #(
  parameter int AW = 12,
  parameter int BW = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      a,
  input  logic [BW-1:0]      b,
  output logic [AW+BW-1:0]   prod
);
  localparam int PW = AW + BW;
  localparam logic [AW-1:0] AMIN = {1'b1, {(AW-1){1'b0}}};
  localparam logic [BW-1:0] BMIN = {1'b1, {(BW-1){1'b0}}};
  localparam logic [PW-1:0] MINSQ = {2'b01, {(PW-2){1'b0}}};

  logic signed [PW-1:0] full;

  always_comb full = $signed(a) * $signed(b);

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else     prod <= full;
  end

  // R2
  min_sq_chk: assert property (@(posedge clk) disable iff (rst)
    (a == AMIN && b == BMIN) |=> (prod == MINSQ));

  // R2
  zero_op_chk: assert property (@(posedge clk) disable iff (rst)
    (a == '0 || b == '0) |=> (prod == '0));
endmodule

// File: rtl/msum_add.sv
module msum_add #(
  parameter int PW = 24,
  parameter int CW = 26
) (
  input  logic [PW-1:0] p,
  input  logic [CW-1:0] c,
  output logic [CW-1:0] sum
);
  logic [CW-1:0] p_ext;

  generate
    if (CW > PW) begin : g_ext
      always_comb p_ext = {{(CW-PW){p[PW-1]}}, p};
    end else begin : g_trunc
      always_comb p_ext = p[CW-1:0];
    end
  endgenerate

  // carry out discarded: wraps modulo 2^CW
  always_comb sum = c + p_ext;

  // R4
  always_comb begin
    if (p == '0) zero_prod_chk: assert (sum == c);
  end
endmodule

// File: rtl/msum_out_stage.sv
module msum_out_stage
  import msum_pkg::*;
#(
  parameter int CW = 26
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] sum_live,
  input  logic          pass,
  input  logic          dis,
  output logic [CW-1:0] sum_out,
  output logic          out_valid
);
  logic [CW-1:0] s_q;
  logic          alive_q;
  osel_e         sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q     <= '0;
      alive_q <= 1'b0;
    end else begin
      s_q     <= sum_live;
      alive_q <= 1'b1;
    end
  end

  always_comb begin
    if (dis)       sel = OSEL_OFF;
    else if (pass) sel = OSEL_LIVE;
    else           sel = OSEL_HELD;
  end

  always_comb begin
    unique case (sel)
      OSEL_LIVE: sum_out = sum_live;
      OSEL_HELD: sum_out = s_q;
      default:   sum_out = '0;
    endcase
    out_valid = (sel != OSEL_OFF);
  end

  // R5
  sreg_cap_chk: assert property (@(posedge clk) disable iff (rst)
    alive_q |-> (s_q == $past(sum_live)));

  // R7
  held_lag_chk: assert property (@(posedge clk) disable iff (rst)
    (alive_q && !pass && !dis) |-> (sum_out == $past(sum_live)));

  // R8
  dis_zero_chk: assert property (@(posedge clk) disable iff (rst)
    dis |-> (sum_out == '0 && !out_valid));
endmodule

// File: rtl/msum_top.sv
module msum_top #(
  parameter int A_W = 12,
  parameter int B_W = 12,
  parameter int C_W = 26
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_in,
  input  logic           a_load,
  input  logic [B_W-1:0] b_in,
  input  logic           b_load,
  input  logic [C_W-1:0] c_in,
  input  logic           c_load,
  input  logic           pass_thru,
  input  logic           out_dis,
  output logic [C_W-1:0] sum_out,
  output logic           out_valid
);
  localparam int P_W = A_W + B_W;

  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic [C_W-1:0] c_q;
  logic [P_W-1:0] p_q;
  logic [C_W-1:0] sum_live;

  msum_ld_reg #(.W(A_W)) u_areg (
    .clk(clk), .rst(rst), .ld(a_load), .d(a_in), .q(a_q));
  msum_ld_reg #(.W(B_W)) u_breg (
    .clk(clk), .rst(rst), .ld(b_load), .d(b_in), .q(b_q));
  msum_ld_reg #(.W(C_W)) u_creg (
    .clk(clk), .rst(rst), .ld(c_load), .d(c_in), .q(c_q));

  msum_mult #(.AW(A_W), .BW(B_W)) u_mult (
    .clk(clk), .rst(rst), .a(a_q), .b(b_q), .prod(p_q));

  msum_add #(.PW(P_W), .CW(C_W)) u_add (
    .p(p_q), .c(c_q), .sum(sum_live));

  msum_out_stage #(.CW(C_W)) u_out (
    .clk(clk), .rst(rst), .sum_live(sum_live), .pass(pass_thru),
    .dis(out_dis), .sum_out(sum_out), .out_valid(out_valid));

  // R6
  live_path_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_thru && !out_dis && c_q == '0) |-> (sum_out == {{(C_W-P_W){p_q[P_W-1]}}, p_q}));
endmodule

// File: tb/msum_top_tb_top.sv
module msum_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] a_in = '0, b_in = '0;
  logic [25:0] c_in = '0;
  logic        a_load = 0, b_load = 0, c_load = 0, pass_thru = 1, out_dis = 0;
  logic [25:0] sum_out;
  logic        out_valid;

  int checks = 0, fails = 0;

  // reference model state
  logic [11:0] ma = '0, mb = '0;
  logic [25:0] mc = '0, ms = '0;
  logic [23:0] mp = '0;

  always #4 clk = ~clk;

  msum_top dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .a_load(a_load), .b_in(b_in),
    .b_load(b_load), .c_in(c_in), .c_load(c_load), .pass_thru(pass_thru),
    .out_dis(out_dis), .sum_out(sum_out), .out_valid(out_valid));

  function automatic logic [23:0] f_mul(logic [11:0] x, logic [11:0] y);
    logic signed [23:0] r;
    r = $signed({{12{x[11]}}, x}) * $signed({{12{y[11]}}, y});
    return r;
  endfunction

  function automatic logic [25:0] f_sum(logic [25:0] c, logic [23:0] p);
    return c + {{2{p[23]}}, p};
  endfunction

  task automatic model_edge();
    logic [25:0] live;
    live = f_sum(mc, mp);
    if (rst) begin
      ma = '0; mb = '0; mc = '0; mp = '0; ms = '0;
    end else begin
      ms = live;
      mp = f_mul(ma, mb);
      if (a_load) ma = a_in;
      if (b_load) mb = b_in;
      if (c_load) mc = c_in;
    end
  endtask

  function automatic logic [25:0] exp_out();
    if (out_dis)   return '0;
    if (pass_thru) return f_sum(mc, mp);
    return ms;
  endfunction

  task automatic check(string tag, logic [25:0] act, logic [25:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %0d (0x%07h) expected %0d (0x%07h)",
               tag, $signed(act), act, $signed(expv), expv);
    end
  endtask

  // one clock: inputs already set before call; compares after edge
  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    #1;
    check(tag, sum_out, exp_out());
    check({tag, " R8 valid"}, {25'd0, out_valid}, {25'd0, !out_dis});
    @(negedge clk);
  endtask

  task automatic drive(logic [11:0] a, logic al, logic [11:0] b, logic bl,
                       logic [25:0] c, logic cl, logic ft, logic od);
    a_in = a; a_load = al; b_in = b; b_load = bl;
    c_in = c; c_load = cl; pass_thru = ft; out_dis = od;
  endtask

  function automatic string mode_tag();
    if (out_dis)   return "R8";
    if (pass_thru) return "R6 R4";
    return "R7 R5";
  endfunction

  logic done = 0;

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd20240517);
    @(negedge clk);
    // R9: loads ignored during reset
    drive(12'h7FF, 1, 12'h7FF, 1, 26'h155, 1, 1, 0);
    tick("R9 reset load ignored");
    tick("R9 reset");
    check("R9 out zero after reset", sum_out, 26'd0);
    rst = 0;
    drive(12'h7FF, 0, 12'h7FF, 0, 26'h155, 0, 1, 0);
    tick("R9 held zero after reset");
    check("R9 sum zero", sum_out, 26'd0);

    // R2: -2048 x -2048 with C=0
    drive(12'h800, 1, 12'h800, 1, 26'd0, 1, 1, 0);
    tick("R1 R2 load");
    drive(12'h000, 0, 12'h000, 0, 26'd0, 0, 1, 0);
    tick("R2 R6 min*min");
    check("R2 min*min value", sum_out, 26'd4194304);

    // R2 R4: -2048 x 2047 plus negative C
    drive(12'h800, 1, 12'h7FF, 1, 26'd0, 0, 1, 0);
    tick("R1 load");
    drive(12'h000, 0, 12'h000, 0, -26'sd1000, 1, 1, 0);
    tick("R4 R6 neg sum");
    check("R4 -2048*2047-1000", sum_out, -26'sd4193256);

    // R1 hold: change inputs with loads low, product unchanged
    drive(12'h123, 0, 12'h456, 0, 26'h3FFFFFF, 0, 1, 0);
    tick("R1 R3 hold");
    check("R1 R3 hold value", sum_out, -26'sd4193256);

    // R4 wrap: 4194304 + (2^25-1) wraps negative
    drive(12'h800, 1, 12'h800, 1, 26'h1FFFFFF, 1, 1, 0);
    tick("R1 R3 load");
    drive(12'h000, 0, 12'h000, 0, 26'd0, 0, 1, 0);
    tick("R4 wrap");
    check("R4 wrap value", sum_out, 26'h1FFFFFF + 26'd4194304);

    // R7: registered path shows previous cycle's sum
    drive(12'h000, 0, 12'h000, 0, 26'd0, 0, 0, 0);
    tick("R7 R5 held");
    check("R7 held value", sum_out, 26'h1FFFFFF + 26'd4194304);

    // R8: disabled
    drive(12'h000, 0, 12'h000, 0, 26'd0, 0, 1, 1);
    tick("R8 disabled");
    check("R8 zero out", sum_out, 26'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] ra, rb;
      logic [25:0] rc;
      int sel;
      sel = $urandom_range(0, 9);
      ra = (sel == 0) ? 12'h800 : (sel == 1) ? 12'h7FF : 12'($urandom);
      rb = (sel == 2) ? 12'h800 : (sel == 3) ? 12'h7FF : 12'($urandom);
      rc = (sel == 4) ? 26'h2000000 : 26'($urandom);
      drive(ra, 1'($urandom), rb, 1'($urandom), rc, 1'($urandom),
            ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0));
      if ($urandom_range(0, 199) == 0) rst = 1; else rst = 0;
      tick(rst ? "R9 random" : mode_tag());
    end
    rst = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule